// File: doc/BRIEF.md
# CAN Bus Lock Detector

This block watches the sampled bit stream of a CAN bus while the controller is in normal operation. It raises a sticky lock flag when the bus has stayed dominant for a long unbroken run of bit times. Each sampled bit arrives together with a one-cycle bit-time strobe. On the clock cycle in which the flag goes high, the block also raises a one-cycle interrupt pulse. A separate live status output reports that the dominant run is still in progress, so that the mode controller can refuse a request to enter halt mode while the bus is stuck.

Software clears the flag with a one-cycle write pulse. Clearing the flag does not start a new count straight away. Detection is armed again only when one of two things happens: a recessive bit is sampled, which shows the lock has gone, or the controller passes through reset mode and comes back into operation mode. Bit timing, synchronisation and frame decoding are handled elsewhere.

Top module: `can_lock_det`

## Requirements
- R1: After reset, `lock_flag_o`, `lock_irq_o` and `bus_locked_o` are all 0.
- R2: In operation mode (`mode_i` = 2'b01), when LOCK_BITS (default 32) consecutive strobed samples are dominant (`bus_bit_i` = 0) and detection is armed, `lock_flag_o` is 1 one clock after the strobe that carries the last of those bits. A run one bit shorter does not set it.
- R3: A strobed recessive sample (`bus_bit_i` = 1) in operation mode ends the dominant run. The run then starts again from zero, and `bus_locked_o` is 0 after that edge.
- R4: Counting happens only in operation mode. In reset (2'b00), halt (2'b10) or sleep (2'b11) mode, strobes are ignored and the run count is held at zero, so a run that is interrupted by another mode does not carry across it.
- R5: `lock_irq_o` is high for exactly one clock, in the cycle in which `lock_flag_o` first reads 1. It stays low while the flag remains set.
- R6: `lock_flag_o` stays 1 until a `flag_clr_i` pulse, and it is 0 in the cycle after that pulse.
- R7: Once the flag has been cleared, further dominant bits do not set it again. A strobed recessive sample in operation mode re-arms detection.
- R8: Once the flag has been cleared, a pass through reset mode followed by a return to operation mode also re-arms detection. A pass through halt mode alone does not.
- R9: When `flag_clr_i` arrives in the same cycle as a new detection, the clear wins. No flag and no interrupt result, and detection stays off until it is re-armed.
- R10: `bus_locked_o` is 1 while the dominant run has reached LOCK_BITS in operation mode. The run count saturates at that value, so a longer dominant run keeps `bus_locked_o` high and never wraps.
- R11: A `flag_clr_i` pulse while the flag is 0 and no detection is pending has no effect. A following lock run still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe, one per sampled bit time |
| bus_bit_i | input | 1 | Sampled bus level: 0 is dominant, 1 is recessive |
| mode_i | input | 2 | Controller mode: 00 reset, 01 operation, 10 halt, 11 sleep |
| flag_clr_i | input | 1 | Software write pulse that clears the lock flag |
| lock_flag_o | output | 1 | Sticky bus-lock flag |
| lock_irq_o | output | 1 | One-cycle interrupt when the flag rises |
| bus_locked_o | output | 1 | Live status: the dominant run is saturated |

## Verification
The following rules hold on every cycle, and the assertions check them continuously:
- the flag is sticky, and a clear always takes effect on the next edge;
- the interrupt matches the flag's rising edge exactly;
- the run count never exceeds its threshold;
- the flag can only rise after a saturated run;
- a recessive strobe or any mode other than operation drops the live status.

The rules about when detection is re-armed need a history of mode changes and clears leading up to a new run, so only the directed scenarios can show them. These cover re-arming through a recessive bit, re-arming through reset mode, the halt mode pass that must not re-arm, and the clear that collides with a detection.

// File: rtl/can_lock_pkg.sv
package can_lock_pkg;
  typedef enum logic [1:0] {
    MODE_RESET = 2'b00,
    MODE_OPER  = 2'b01,
    MODE_HALT  = 2'b10,
    MODE_SLEEP = 2'b11
  } can_mode_e;

  localparam logic BIT_DOMINANT  = 1'b0;
  localparam logic BIT_RECESSIVE = 1'b1;
endpackage

// File: rtl/dom_run_cnt.sv
module dom_run_cnt
  import can_lock_pkg::*;
#(
  parameter int unsigned LOCK_BITS = 32,
  localparam int unsigned CW = $clog2(LOCK_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          oper_i,
  input  logic          stb_i,
  input  logic          bus_bit_i,
  output logic [CW-1:0] run_cnt_o,
  output logic          sat_o
);
  localparam logic [CW-1:0] MAX_CNT = CW'(LOCK_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!oper_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (bus_bit_i == BIT_DOMINANT) begin
        if (cnt_q != MAX_CNT) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign run_cnt_o = cnt_q;
  assign sat_o     = (cnt_q == MAX_CNT);
endmodule

// File: rtl/rearm_ctrl.sv
module rearm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oper_i,
  input  logic reset_mode_i,
  input  logic rec_stb_i,
  input  logic disarm_i,
  output logic armed_o
);
  logic armed_q;
  logic via_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b1;
      via_rst_q <= 1'b0;
    end else if (disarm_i) begin
      armed_q   <= 1'b0;
      via_rst_q <= 1'b0;
    end else if (!armed_q) begin
      if (rec_stb_i) begin
        armed_q   <= 1'b1;
        via_rst_q <= 1'b0;
      end else if (via_rst_q && oper_i) begin
        armed_q   <= 1'b1;
        via_rst_q <= 1'b0;
      end else if (reset_mode_i) begin
        via_rst_q <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/lock_flag.sv
module lock_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_req_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o,
  output logic disarm_o
);
  logic flag_q, irq_q;
  logic clr_eff, set_eff;

  // a clear counts only when it removes a flag or vetoes a detection
  assign clr_eff  = clr_i & (flag_q | set_req_i);
  assign set_eff  = set_req_i & ~clr_i & ~flag_q;
  assign disarm_o = clr_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= set_eff;
      if (clr_eff)      flag_q <= 1'b0;
      else if (set_eff) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/can_lock_det.sv
module can_lock_det
  import can_lock_pkg::*;
#(
  parameter int unsigned LOCK_BITS = 32,
  localparam int unsigned CW = $clog2(LOCK_BITS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_stb_i,
  input  logic       bus_bit_i,
  input  logic [1:0] mode_i,
  input  logic       flag_clr_i,
  output logic       lock_flag_o,
  output logic       lock_irq_o,
  output logic       bus_locked_o
);
  can_mode_e     mode;
  logic          oper, reset_mode, rec_stb;
  logic [CW-1:0] run_cnt;
  logic          sat, armed, disarm;

  assign mode       = can_mode_e'(mode_i);
  assign oper       = (mode == MODE_OPER);
  assign reset_mode = (mode == MODE_RESET);
  assign rec_stb    = bit_stb_i & oper & (bus_bit_i == BIT_RECESSIVE);

  dom_run_cnt #(.LOCK_BITS(LOCK_BITS)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oper_i    (oper),
    .stb_i     (bit_stb_i),
    .bus_bit_i (bus_bit_i),
    .run_cnt_o (run_cnt),
    .sat_o     (sat)
  );

  rearm_ctrl i_rearm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oper_i       (oper),
    .reset_mode_i (reset_mode),
    .rec_stb_i    (rec_stb),
    .disarm_i     (disarm),
    .armed_o      (armed)
  );

  lock_flag i_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_req_i (sat & armed),
    .clr_i     (flag_clr_i),
    .flag_o    (lock_flag_o),
    .irq_o     (lock_irq_o),
    .disarm_o  (disarm)
  );

  assign bus_locked_o = sat;
endmodule

// File: rtl/can_lock_det_chk.sv
module can_lock_det_chk #(
  parameter int unsigned LOCK_BITS = 32,
  localparam int unsigned CW = $clog2(LOCK_BITS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_stb_i,
  input logic          bus_bit_i,
  input logic [1:0]    mode_i,
  input logic          flag_clr_i,
  input logic          lock_flag_o,
  input logic          lock_irq_o,
  input logic          bus_locked_o,
  input logic [CW-1:0] run_cnt
);
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CW'(LOCK_BITS));

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_flag_o && !flag_clr_i |=> lock_flag_o);

  // R6
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !lock_flag_o);

  // R5
  irq_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_flag_o) |-> lock_irq_o);

  // R5
  irq_only_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_irq_o |-> $rose(lock_flag_o));

  // R2
  rise_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_flag_o) |-> $past(bus_locked_o));

  // R3
  recessive_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_i && bus_bit_i && mode_i == 2'b01 |=> !bus_locked_o);

  // R4
  idle_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 2'b01 |=> !bus_locked_o);
endmodule

bind can_lock_det can_lock_det_chk #(.LOCK_BITS(LOCK_BITS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_stb_i    (bit_stb_i),
  .bus_bit_i    (bus_bit_i),
  .mode_i       (mode_i),
  .flag_clr_i   (flag_clr_i),
  .lock_flag_o  (lock_flag_o),
  .lock_irq_o   (lock_irq_o),
  .bus_locked_o (bus_locked_o),
  .run_cnt      (run_cnt)
);

// File: tb/test_can_lock_det.sv
`timescale 1ns/1ps
module test_can_lock_det;
  localparam int unsigned LOCK_BITS = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bit_stb_i = 1'b0, bus_bit_i = 1'b1, flag_clr_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic lock_flag_o, lock_irq_o, bus_locked_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  can_lock_det #(.LOCK_BITS(LOCK_BITS)) i_can_lock_det (
    .clk_i(clk), .rst_ni(rst_ni), .bit_stb_i(bit_stb_i), .bus_bit_i(bus_bit_i),
    .mode_i(mode_i), .flag_clr_i(flag_clr_i), .lock_flag_o(lock_flag_o),
    .lock_irq_o(lock_irq_o), .bus_locked_o(bus_locked_o)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  // strobe one bit, then one idle cycle; flag/irq visible on return
  task automatic send_bit(input logic b);
    @(negedge clk); bit_stb_i = 1'b1; bus_bit_i = b;
    @(negedge clk); bit_stb_i = 1'b0; bus_bit_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_dom(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_i = m;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; mode_i = 2'b00; bit_stb_i = 1'b0; flag_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    set_mode(2'b01);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(lock_flag_o, 1'b0, "R1 flag after reset");
    check(lock_irq_o, 1'b0, "R1 irq after reset");
    check(bus_locked_o, 1'b0, "R1 locked after reset");
  endtask

  task automatic t_detect();
    do_reset();
    send_dom(LOCK_BITS - 1);
    check(lock_flag_o, 1'b0, "R2 one bit short");
    check(bus_locked_o, 1'b0, "R10 locked one bit short");
    send_bit(1'b0);
    check(lock_flag_o, 1'b1, "R2 flag at threshold");
    check(lock_irq_o, 1'b1, "R5 irq on rise");
    check(bus_locked_o, 1'b1, "R10 locked at threshold");
    @(negedge clk);
    check(lock_irq_o, 1'b0, "R5 irq one cycle");
    send_dom(70);
    check(bus_locked_o, 1'b1, "R10 saturated long run");
    check(lock_irq_o, 1'b0, "R5 no irq while set");
    check(lock_flag_o, 1'b1, "R6 flag sticky");
    send_bit(1'b1);
    check(bus_locked_o, 1'b0, "R3 recessive drops locked");
    check(lock_flag_o, 1'b1, "R6 sticky across recessive");
    clear_flag();
    check(lock_flag_o, 1'b0, "R6 cleared");
  endtask

  task automatic t_recessive_break();
    do_reset();
    send_dom(LOCK_BITS - 1);
    send_bit(1'b1);
    send_dom(LOCK_BITS - 1);
    check(lock_flag_o, 1'b0, "R3 run restarted");
    send_bit(1'b0);
    check(lock_flag_o, 1'b1, "R3 full run after break");
  endtask

  task automatic t_modes();
    do_reset();
    set_mode(2'b00);
    send_dom(LOCK_BITS + 8);
    check(lock_flag_o, 1'b0, "R4 reset mode ignored");
    check(bus_locked_o, 1'b0, "R4 reset mode no lock");
    set_mode(2'b01);
    send_dom(20);
    set_mode(2'b10);
    set_mode(2'b01);
    send_dom(20);
    check(lock_flag_o, 1'b0, "R4 halt breaks run");
    send_dom(LOCK_BITS - 20);
    check(lock_flag_o, 1'b1, "R4 full run after halt");
  endtask

  task automatic t_rearm_recessive();
    do_reset();
    send_dom(LOCK_BITS);
    clear_flag();
    send_dom(40);
    check(lock_flag_o, 1'b0, "R7 no reset without rearm");
    check(bus_locked_o, 1'b1, "R10 locked while disarmed");
    send_bit(1'b1);
    send_dom(LOCK_BITS);
    check(lock_flag_o, 1'b1, "R7 rearmed by recessive");
  endtask

  task automatic t_rearm_mode();
    do_reset();
    send_dom(LOCK_BITS);
    clear_flag();
    set_mode(2'b10);
    set_mode(2'b01);
    send_dom(LOCK_BITS + 2);
    check(lock_flag_o, 1'b0, "R8 halt does not rearm");
    set_mode(2'b00);
    set_mode(2'b01);
    send_dom(LOCK_BITS);
    check(lock_flag_o, 1'b1, "R8 reset pass rearms");
  endtask

  task automatic t_collision();
    do_reset();
    send_dom(LOCK_BITS - 1);
    @(negedge clk); bit_stb_i = 1'b1; bus_bit_i = 1'b0;
    @(negedge clk); bit_stb_i = 1'b0; bus_bit_i = 1'b1; flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    check(lock_flag_o, 1'b0, "R9 clear wins");
    check(lock_irq_o, 1'b0, "R9 no irq");
    send_dom(10);
    check(lock_flag_o, 1'b0, "R9 held off");
    send_bit(1'b1);
    send_dom(LOCK_BITS);
    check(lock_flag_o, 1'b1, "R9 detects after rearm");
  endtask

  task automatic t_idle_clear();
    do_reset();
    send_dom(5);
    clear_flag();
    check(lock_flag_o, 1'b0, "R11 idle clear no flag");
    send_dom(LOCK_BITS - 5);
    check(lock_flag_o, 1'b1, "R11 idle clear no effect");
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_detect();
    t_recessive_break();
    t_modes();
    t_rearm_recessive();
    t_rearm_mode();
    t_collision();
    t_idle_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule